// File: doc/BRIEF.md
# FSK Caller-ID Character Receiver

This block turns an already demodulated caller-ID bit stream into bytes. An analog front end supplies two signals: the sliced mark/space level and a flag saying that an in-band tone above the minimum level is present. The block synchronises both. It hunts for a start bit and times each bit from an oversampling tick taken from the system clock. It samples eight data bits at their centres and writes the finished byte into a data register. Software learns of each byte through a status flag and an interrupt line. Both clear when software reads the status register.

Software controls reception through a function register. Only the receive-enable bit and two sibling mode bits, which belong to other caller-ID modes, have any effect. The interrupt is raised as soon as the eighth data bit is taken, before the stop bit. A stop bit sampled at space level sets an extra error flag.

Top module: `fsk_cid_rx`

## Requirements
- R1: Reception runs only while function register (address 0, read/write) bit 2 is 1 and bits 1 and 5 are both 0. Values 0x06, 0x24 and 0x00 block every frame.
- R2: While the carrier input is low, no frame is started or completed.
- R3: A frame starts on a 1-to-0 edge of the line. The start bit is accepted only if the line is still 0 at mid-bit. A low pulse shorter than half a bit returns the block to hunting with no flag set.
- R4: The eight data bits arrive least significant bit first. The received byte is readable at address 2.
- R5: Once the eighth data bit is sampled, status bit 2 (address 1) and irq_o are set while the stop bit is still on the line.
- R6: A read of address 1 returns the flags and clears them. irq_o then drops, and a second read returns 0.
- R7: Frames whose bit period is off by up to 1% from nominal are received correctly.
- R8: A stop bit sampled as 0 sets status bit 3 and irq_o. A status read clears that bit.
- R9: If a byte completes in the same cycle as a status read, the flag is still set, and it is visible to the next read cycle.
- R10: Clearing the enable, or losing carrier mid-frame, abandons the frame at once. No flag is set, the data register keeps its value, and the next frame is received normally.
- R11: After reset all registers read 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Sliced line level, 1 = mark, 0 = space |
| carrier_i | input | 1 | In-band signal above threshold |
| reg_sel_i | input | 1 | Register access strobe |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid while a read is strobed |
| irq_o | output | 1 | Interrupt, high while any status flag is set |

## Verification
The hardest case to reach from the ports is a status read that lands in exactly the cycle when the eighth bit completes. The exact cycle depends on synchroniser delay and tick phase. The bench does not try to hit it. Instead it holds a status read strobe on every cycle across the whole window in which the eighth sample can fall. This makes the collision certain. The bench then counts how many cycles show the ready flag, and exactly one is correct.

// File: rtl/fsk_cid_pkg.sv
package fsk_cid_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_FUNC = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  // function register bits
  localparam int unsigned FN_RX_EN  = 2;
  localparam int unsigned FN_MODE_A = 1;
  localparam int unsigned FN_MODE_B = 5;
  // status register bits
  localparam int unsigned ST_RDY  = 2;
  localparam int unsigned ST_FERR = 3;

  typedef enum logic [1:0] {RX_HUNT, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/fsk_cid_tick.sv
module fsk_cid_tick #(
  parameter int unsigned DIV = 2604
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i || cnt_q == LAST)   cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST) && !clr_i;
endmodule

// File: rtl/fsk_cid_frame.sv
module fsk_cid_frame
  import fsk_cid_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OS_RATE     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rx_bit_i,
  input  logic              carrier_i,
  input  logic              tick_i,
  output logic              start_o,
  output logic              busy_o,
  output logic              carrier_ok_o,
  output logic              byte_done_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              frame_err_o
);
  localparam int unsigned OW = (OS_RATE > 1) ? $clog2(OS_RATE) : 1;
  localparam int unsigned BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [OW-1:0] OS_MID  = OW'(OS_RATE / 2 - 1);
  localparam logic [OW-1:0] OS_LAST = OW'(OS_RATE - 1);
  localparam logic [BW-1:0] IDX_LAST = BW'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] bit_sync_q, car_sync_q;
  logic                   bit_s, car_s, prev_q, live, centre;
  rx_state_e              state_q;
  logic [OW-1:0]          os_q;
  logic [BW-1:0]          idx_q;
  logic [DATA_W-1:0]      sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_sync_q <= '1;
      car_sync_q <= '0;
      prev_q     <= 1'b1;
    end else begin
      bit_sync_q <= {bit_sync_q[SYNC_STAGES-2:0], rx_bit_i};
      car_sync_q <= {car_sync_q[SYNC_STAGES-2:0], carrier_i};
      prev_q     <= bit_s;
    end
  end

  assign bit_s  = bit_sync_q[SYNC_STAGES-1];
  assign car_s  = car_sync_q[SYNC_STAGES-1];
  assign live   = en_i && car_s;
  assign centre = tick_i && (os_q == OS_LAST);

  assign start_o = (state_q == RX_HUNT) && live && prev_q && !bit_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_HUNT;
      os_q    <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
    end else if (state_q != RX_HUNT && !live) begin
      state_q <= RX_HUNT;  // abort
    end else begin
      unique case (state_q)
        RX_HUNT: if (start_o) begin
          state_q <= RX_START;
          os_q    <= '0;
        end
        RX_START: if (tick_i) begin
          if (os_q == OS_MID) begin
            if (!bit_s) begin
              state_q <= RX_DATA;
              os_q    <= '0;
              idx_q   <= '0;
            end else begin
              state_q <= RX_HUNT;
            end
          end else begin
            os_q <= os_q + 1'b1;
          end
        end
        RX_DATA: if (tick_i) begin
          if (centre) begin
            os_q  <= '0;
            sh_q  <= {bit_s, sh_q[DATA_W-1:1]};
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_LAST) state_q <= RX_STOP;
          end else begin
            os_q <= os_q + 1'b1;
          end
        end
        RX_STOP: if (tick_i) begin
          if (centre) state_q <= RX_HUNT;
          else        os_q    <= os_q + 1'b1;
        end
        default: state_q <= RX_HUNT;
      endcase
    end
  end

  assign byte_o       = {bit_s, sh_q[DATA_W-1:1]};
  assign byte_done_o  = live && (state_q == RX_DATA) && centre && (idx_q == IDX_LAST);
  assign frame_err_o  = live && (state_q == RX_STOP) && centre && !bit_s;
  assign busy_o       = (state_q != RX_HUNT);
  assign carrier_ok_o = car_s;
endmodule

// File: rtl/fsk_cid_regs.sv
module fsk_cid_regs
  import fsk_cid_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              byte_done_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              frame_err_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              rx_en_o,
  output logic              irq_o,
  output logic              rdy_o,
  output logic              ferr_o,
  output logic              stat_rd_o,
  output logic [DATA_W-1:0] data_o
);
  logic [BUS_W-1:0]  fn_q, stat;
  logic [DATA_W-1:0] data_q;
  logic              rdy_q, ferr_q, fn_wr, stat_rd;

  assign fn_wr   = sel_i && wr_i && (addr_i == ADDR_FUNC);
  assign stat_rd = sel_i && !wr_i && (addr_i == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fn_q   <= '0;
      data_q <= '0;
      rdy_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      if (fn_wr) fn_q <= wdata_i;
      if (byte_done_i) data_q <= byte_i;
      // set wins over clear-on-read
      if (byte_done_i)  rdy_q <= 1'b1;
      else if (stat_rd) rdy_q <= 1'b0;
      if (frame_err_i)  ferr_q <= 1'b1;
      else if (stat_rd) ferr_q <= 1'b0;
    end
  end

  always_comb begin
    stat          = '0;
    stat[ST_RDY]  = rdy_q;
    stat[ST_FERR] = ferr_q;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !wr_i) begin
      unique case (addr_i)
        ADDR_FUNC: rdata_o = fn_q;
        ADDR_STAT: rdata_o = stat;
        ADDR_DATA: rdata_o = BUS_W'(data_q);
        default:   rdata_o = '0;
      endcase
    end
  end

  assign rx_en_o   = fn_q[FN_RX_EN] && !fn_q[FN_MODE_A] && !fn_q[FN_MODE_B];
  assign irq_o     = rdy_q || ferr_q;
  assign rdy_o     = rdy_q;
  assign ferr_o    = ferr_q;
  assign stat_rd_o = stat_rd;
  assign data_o    = data_q;
endmodule

// File: rtl/fsk_cid_rx.sv
module fsk_cid_rx
  import fsk_cid_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned BAUD    = 1200,
  parameter int unsigned OS_RATE = 16,
  parameter int unsigned DATA_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_bit_i,
  input  logic             carrier_i,
  input  logic             reg_sel_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic             irq_o
);
  localparam int unsigned DIV_RAW = CLK_HZ / (BAUD * OS_RATE);
  localparam int unsigned DIV     = (DIV_RAW > 0) ? DIV_RAW : 1;

  logic              tick, start, busy, carrier_ok, byte_done, frame_err;
  logic              rx_en, rdy_q, ferr_q, stat_rd;
  logic [DATA_W-1:0] rx_byte, data_q;

  fsk_cid_tick #(.DIV(DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .tick_o (tick)
  );

  fsk_cid_frame #(.DATA_W(DATA_W), .OS_RATE(OS_RATE), .SYNC_STAGES(2)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (rx_en),
    .rx_bit_i     (rx_bit_i),
    .carrier_i    (carrier_i),
    .tick_i       (tick),
    .start_o      (start),
    .busy_o       (busy),
    .carrier_ok_o (carrier_ok),
    .byte_done_o  (byte_done),
    .byte_o       (rx_byte),
    .frame_err_o  (frame_err)
  );

  fsk_cid_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (reg_sel_i),
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .byte_done_i (byte_done),
    .byte_i      (rx_byte),
    .frame_err_i (frame_err),
    .rdata_o     (reg_rdata_o),
    .rx_en_o     (rx_en),
    .irq_o       (irq_o),
    .rdy_o       (rdy_q),
    .ferr_o      (ferr_q),
    .stat_rd_o   (stat_rd),
    .data_o      (data_q)
  );
endmodule

// File: rtl/fsk_cid_rx_chk.sv
module fsk_cid_rx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en,
  input logic              busy,
  input logic              carrier_ok,
  input logic              byte_done,
  input logic              frame_err,
  input logic              stat_rd,
  input logic              rdy,
  input logic              ferr,
  input logic              irq,
  input logic [DATA_W-1:0] data
);
  p_idle_when_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en |=> !busy);

  p_idle_no_carrier_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carrier_ok |=> !busy);

  p_single_event_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_done && frame_err));

  // also covers R9: set holds even when a read coincides
  p_flag_after_byte_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done |=> rdy && irq);

  p_rdy_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !byte_done) |=> !rdy);

  p_ferr_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err |=> ferr && irq);

  p_ferr_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !frame_err) |=> !ferr);

  p_data_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_done |=> $stable(data));
endmodule

bind fsk_cid_rx fsk_cid_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_en      (rx_en),
  .busy       (busy),
  .carrier_ok (carrier_ok),
  .byte_done  (byte_done),
  .frame_err  (frame_err),
  .stat_rd    (stat_rd),
  .rdy        (rdy_q),
  .ferr       (ferr_q),
  .irq        (irq_o),
  .data       (data_q)
);

// File: tb/fsk_cid_rx_bench.sv
`timescale 1ns/1ps
module fsk_cid_rx_bench;
  localparam int unsigned BAUD   = 1200;
  localparam int unsigned OS     = 16;
  localparam int unsigned DIVB   = 8;
  localparam int unsigned CLK_HZ = BAUD * OS * DIVB;
  localparam int          PER    = OS * DIVB;  // clocks per bit

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_bit = 1'b1;
  logic       carrier = 1'b1;
  logic       sel = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  fsk_cid_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OS_RATE(OS), .DATA_W(8)) u_fsk_cid_rx (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rx_bit_i    (rx_bit),
    .carrier_i   (carrier),
    .reg_sel_i   (sel),
    .reg_wr_i    (wr),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  function automatic logic [7:0] exp_stat(input bit rdy, input bit ferr);
    exp_stat = 8'h00;
    exp_stat[2] = rdy;
    exp_stat[3] = ferr;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input bit stop, input int per, input bit chk_mid);
    @(negedge clk);
    rx_bit = 1'b0;
    repeat (per) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_bit = d[i];
      repeat (per) @(negedge clk);
    end
    rx_bit = stop;
    repeat (per / 2) @(negedge clk);
    if (chk_mid) check(irq === 1'b1, "R5 irq during stop bit", int'(irq), 1);
    repeat (per - per / 2) @(negedge clk);
    rx_bit = 1'b1;
    repeat (2 * per) @(negedge clk);
  endtask

  task automatic expect_byte(input logic [7:0] d, input string req);
    logic [7:0] v;
    bus_read(2'd1, v);
    check(v == exp_stat(1, 0), {req, " status"}, v, exp_stat(1, 0));
    bus_read(2'd2, v);
    check(v == d, {req, " data"}, v, d);
  endtask

  task automatic expect_nothing(input logic [7:0] keep, input string req);
    logic [7:0] v;
    check(irq === 1'b0, {req, " irq"}, int'(irq), 0);
    bus_read(2'd1, v);
    check(v == 8'h00, {req, " status"}, v, 0);
    bus_read(2'd2, v);
    check(v == keep, {req, " data kept"}, v, keep);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] v, last, b;
    int seen;
    void'($urandom(32'h0C1D_5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 reset state
    check(irq === 1'b0, "R11 irq", int'(irq), 0);
    for (int a = 0; a < 3; a++) begin
      bus_read(2'(a), v);
      check(v == 8'h00, "R11 register", v, 0);
    end

    // R1 enable and read back
    bus_write(2'd0, 8'h04);
    bus_read(2'd0, v);
    check(v == 8'h04, "R1 function readback", v, 8'h04);

    // R5/R6/R4 directed byte
    send_frame(8'hA5, 1'b1, PER, 1'b1);
    bus_read(2'd1, v);
    check(v == exp_stat(1, 0), "R6 first status read", v, exp_stat(1, 0));
    check(irq === 1'b0, "R6 irq after read", int'(irq), 0);
    bus_read(2'd1, v);
    check(v == 8'h00, "R6 second status read", v, 0);
    bus_read(2'd2, v);
    check(v == 8'hA5, "R4 data lsb first", v, 8'hA5);

    // R4 random bytes at nominal rate
    for (int k = 0; k < 6; k++) begin
      b = 8'($urandom);
      send_frame(b, 1'b1, PER, 1'b0);
      expect_byte(b, "R4 random");
    end
    send_frame(8'h01, 1'b1, PER, 1'b0); expect_byte(8'h01, "R4 bit0 only");
    send_frame(8'h80, 1'b1, PER, 1'b0); expect_byte(8'h80, "R4 bit7 only");

    // R7 rate tolerance
    for (int k = 0; k < 4; k++) begin
      b = 8'($urandom);
      send_frame(b, 1'b1, (k % 2) ? PER + 1 : PER - 1, 1'b0);
      expect_byte(b, "R7 off-rate");
    end
    last = b;

    // R1 blocking combinations
    bus_write(2'd0, 8'h06);
    send_frame(8'h3C, 1'b1, PER, 1'b0);
    expect_nothing(last, "R1 mode bit1 set");
    bus_write(2'd0, 8'h24);
    send_frame(8'h3C, 1'b1, PER, 1'b0);
    expect_nothing(last, "R1 mode bit5 set");
    bus_write(2'd0, 8'h00);
    send_frame(8'h3C, 1'b1, PER, 1'b0);
    expect_nothing(last, "R1 enable clear");
    bus_write(2'd0, 8'h04);

    // R2 no carrier
    carrier = 1'b0;
    send_frame(8'h77, 1'b1, PER, 1'b0);
    expect_nothing(last, "R2 carrier low");
    carrier = 1'b1;
    repeat (4) @(negedge clk);

    // R3 short glitch
    rx_bit = 1'b0;
    repeat (PER / 6) @(negedge clk);
    rx_bit = 1'b1;
    repeat (3 * PER) @(negedge clk);
    expect_nothing(last, "R3 glitch rejected");
    send_frame(8'h3C, 1'b1, PER, 1'b0);
    expect_byte(8'h3C, "R3 frame after glitch");
    last = 8'h3C;

    // R8 framing error
    send_frame(8'h5A, 1'b0, PER, 1'b0);
    check(irq === 1'b1, "R8 irq", int'(irq), 1);
    bus_read(2'd1, v);
    check(v == exp_stat(1, 1), "R8 status", v, exp_stat(1, 1));
    bus_read(2'd1, v);
    check(v == 8'h00, "R8 cleared", v, 0);
    bus_read(2'd2, v);
    check(v == 8'h5A, "R8 data", v, 8'h5A);
    last = 8'h5A;

    // R10 carrier loss mid-frame
    fork
      send_frame(8'hC3, 1'b1, PER, 1'b0);
      begin
        repeat (5 * PER + 20) @(negedge clk);
        carrier = 1'b0;
      end
    join
    carrier = 1'b1;
    repeat (4) @(negedge clk);
    expect_nothing(last, "R10 carrier abort");

    // R10 disable mid-frame
    fork
      send_frame(8'hC3, 1'b1, PER, 1'b0);
      begin
        repeat (4 * PER + PER / 2) @(negedge clk);
        bus_write(2'd0, 8'h00);
      end
    join
    bus_write(2'd0, 8'h04);
    expect_nothing(last, "R10 enable abort");
    send_frame(8'h96, 1'b1, PER, 1'b0);
    expect_byte(8'h96, "R10 recovery");

    // R9 read strobe held across byte completion
    seen = 0;
    fork
      send_frame(8'h69, 1'b1, PER, 1'b0);
      begin
        repeat (8 * PER) @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = 2'd1;
        for (int k = 0; k < 2 * PER; k++) begin
          #1 if (rdata[2]) seen++;
          @(negedge clk);
        end
        sel = 1'b0;
      end
    join
    check(seen == 1, "R9 flag visible once", seen, 1);
    bus_read(2'd1, v);
    check(v == 8'h00, "R9 cleared after", v, 0);
    bus_read(2'd2, v);
    check(v == 8'h69, "R9 data", v, 8'h69);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule